// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register Block

This block holds the byte-addressed I/O registers of a two-channel disk bus-master DMA controller. Each channel owns an 8-byte window. The window holds a command byte, a view of a mode byte that both channels share, a status byte that mixes bit kinds, a per-channel timing byte and a 32-bit descriptor-table pointer. The DMA engine beside the block reads the command and pointer fields, and it reports busy and fault conditions back into status.

The two per-channel interrupt lines are latched as pending flags in the shared mode byte. A mask bit per channel gates each flag, and the masked flags are ORed into one shared interrupt level. A build parameter selects a reduced variant. In that variant the mode and timing bytes do not exist: they read as all ones, writes to them are dropped, and no channel can be masked.

Top module: `busmaster_regs`

## Requirements
- R1: The address is 4 bits. Bit 3 selects the channel, so channel 1 starts at byte 8. Bits 2:0 select the byte: 0 command, 1 mode, 2 status, 3 timing, 4..7 descriptor pointer. Byte 4 holds the pointer's least significant byte.
- R2: Each channel's command byte is a plain 8-bit read/write register, written by byte writes (size code 0) only.
- R3: A byte write to status builds the new value as follows. Bits 6:5 are taken from the write data. Bit 0 keeps its previous value for that cycle. Bits 2:1 clear where the data bit is 1 and otherwise hold. Bits 7, 4 and 3 become 0. Outside a write, bit 0 follows the channel's busy input one cycle later.
- R4: A high fault input sets status bit 1, and a rising edge on the channel's interrupt input sets status bit 2. A set wins over a same-cycle clear.
- R5: Byte 1 of either window reads the same shared mode byte. Bits 2 and 3 are the pending flags of channels 0 and 1, and each follows its interrupt input one cycle after an edge. Bits 4 and 5 are the masks of channels 0 and 1. A write changes only bits 4 and 5. Bits 0, 1, 6 and 7 read 0.
- R6: irq_out equals (pending0 AND NOT mask0) OR (pending1 AND NOT mask1) and is registered, so it follows a pending or mask change by one cycle.
- R7: Each channel has its own full 8-bit timing byte, independent of the other channel.
- R8: The descriptor pointer accepts byte (size 0), halfword (size 1, lanes chosen by address bit 1) and word (size 2) writes. Halfword data comes from wr_data[15:0] and word data from wr_data[31:0]. Every pointer write also loads that channel's current-address output with the merged new pointer.
- R9: Reset is synchronous and active high. It clears every register to 0, except that status bits 6:5 take the value of parameter ST_EN_RST (default 01, so status resets to 0x20). irq_out is low after reset.
- R10: A read returns its byte on rd_data one cycle after rd_en, with rd_valid high for exactly that cycle. Reads change no state.
- R11: With EXT_REGS=0, reads of bytes 1 and 3 return 0xFF, writes to them have no effect, and the masks stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word |
| wr_data | input | 32 | Write data, low-aligned |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data is valid |
| chan_busy | input | 2 | Per-channel busy level into status bit 0 |
| chan_fault | input | 2 | Per-channel fault, sets status bit 1 |
| chan_irq | input | 2 | Per-channel interrupt level |
| irq_out | output | 1 | Shared masked interrupt level |
| cur_addr | output | 64 | Current-address registers, channel 0 in bits 31:0 |

## Verification
A wrong pending flag or mask shows up on irq_out within two cycles of an interrupt edge or mask write. It is also visible on the next read of byte 1. A status bit with the wrong kind shows up on the first read that follows a write with a one in that position. A lost bit-0 hold shows up only in a read issued directly after a status write while busy falls. Pointer lane errors surface at once on cur_addr, without a read.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int NUM_CH    = 2;
  localparam int WIN_BYTES = 8;
  localparam int REG_W     = 8;
  localparam int PTR_W     = 32;
  localparam int LANES     = PTR_W / REG_W;
  localparam int ADDR_W    = $clog2(NUM_CH * WIN_BYTES);
  localparam int OFF_W     = $clog2(WIN_BYTES);

  localparam logic [OFF_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_MODE = 3'd1;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd2;
  localparam logic [OFF_W-1:0] OFF_TIME = 3'd3;

  localparam int PEND_LSB = 2;
  localparam int MASK_LSB = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } wsize_e;
endpackage

// File: rtl/bmr_chan_regs.sv
module bmr_chan_regs
  import bmr_pkg::*;
#(
  parameter bit         EXT       = 1'b1,
  parameter logic [1:0] ST_EN_RST = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [1:0]       wr_size,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             busy,
  input  logic             fault,
  input  logic             irq_rise,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] time_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] cur_q
);
  localparam logic [REG_W-1:0] STAT_RST = {1'b0, ST_EN_RST, 5'b0};

  logic             byte_wr;
  logic             ptr_hit;
  logic [LANES-1:0] be;
  logic [PTR_W-1:0] ptr_nx;
  logic [REG_W-1:0] stat_nx;

  assign byte_wr = wr_en && (wr_size == SZ_BYTE);
  assign ptr_hit = wr_en && wr_off[OFF_W-1];

  // byte lane steering for the descriptor pointer
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [REG_W-1:0] lane_d;
    assign be[k] = ptr_hit &&
                   ((wr_size == SZ_BYTE) ? (wr_off[1:0] == 2'(k)) :
                    (wr_size == SZ_HALF) ? (wr_off[1] == 1'(k / 2)) :
                    (wr_size == SZ_WORD));
    assign lane_d = (wr_size == SZ_WORD) ? wr_data[REG_W*k +: REG_W] :
                    (wr_size == SZ_HALF) ? wr_data[REG_W*(k % 2) +: REG_W] :
                                           wr_data[REG_W-1:0];
    assign ptr_nx[REG_W*k +: REG_W] = be[k] ? lane_d : ptr_q[REG_W*k +: REG_W];
  end

  // status: bit0 engine-owned, bits 2:1 sticky with write-one-clear, 6:5 plain
  always_comb begin
    stat_nx    = stat_q;
    stat_nx[0] = busy;
    if (byte_wr && wr_off == OFF_STAT) begin
      stat_nx = {1'b0, wr_data[6:5], 2'b00,
                 stat_q[2:1] & ~wr_data[2:1], stat_q[0]};
    end
    if (fault)    stat_nx[1] = 1'b1;
    if (irq_rise) stat_nx[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      stat_q <= STAT_RST;
      ptr_q  <= '0;
      cur_q  <= '0;
    end else begin
      stat_q <= stat_nx;
      if (byte_wr && wr_off == OFF_CMD) cmd_q <= wr_data[REG_W-1:0];
      if (|be) begin
        ptr_q <= ptr_nx;
        cur_q <= ptr_nx;
      end
    end
  end

  if (EXT) begin : g_time
    always_ff @(posedge clk) begin
      if (rst)                               time_q <= '0;
      else if (byte_wr && wr_off == OFF_TIME) time_q <= wr_data[REG_W-1:0];
    end
  end else begin : g_no_time
    assign time_q = '0;
  end
endmodule

// File: rtl/bmr_mode_irq.sv
module bmr_mode_irq
  import bmr_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_irq,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] mask_wd,
  output logic [REG_W-1:0]  mode_q,
  output logic              irq_out
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] mask_q;

  // pending flag tracks each line, so every edge sets or clears it
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= chan_irq;
  end

  if (EXT) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)          mask_q <= '0;
      else if (mask_we) mask_q <= mask_wd;
    end
  end else begin : g_no_mask
    assign mask_q = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_q & ~mask_q);
  end

  always_comb begin
    mode_q = '0;
    mode_q[PEND_LSB +: NUM_CH] = pend_q;
    mode_q[MASK_LSB +: NUM_CH] = mask_q;
  end
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import bmr_pkg::*;
#(
  parameter bit         EXT_REGS  = 1'b1,
  parameter logic [1:0] ST_EN_RST = 2'b01
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [1:0]              wr_size,
  input  logic [PTR_W-1:0]        wr_data,
  input  logic                    rd_en,
  output logic [REG_W-1:0]        rd_data,
  output logic                    rd_valid,
  input  logic [NUM_CH-1:0]       chan_busy,
  input  logic [NUM_CH-1:0]       chan_fault,
  input  logic [NUM_CH-1:0]       chan_irq,
  output logic                    irq_out,
  output logic [NUM_CH*PTR_W-1:0] cur_addr
);
  localparam logic [REG_W-1:0] ABSENT = '1;

  logic [OFF_W-1:0]                  off;
  logic                              sel;
  logic [NUM_CH-1:0]                 irq_prev_q;
  logic [NUM_CH-1:0]                 irq_rise;
  logic [NUM_CH-1:0][REG_W-1:0]      cmd_a, stat_a, time_a;
  logic [NUM_CH-1:0][PTR_W-1:0]      ptr_a, cur_a;
  logic [REG_W-1:0]                  mode_w;
  logic                              mask_we;
  logic [REG_W-1:0]                  rd_nx;

  assign off      = addr[OFF_W-1:0];
  assign sel      = addr[ADDR_W-1];
  assign irq_rise = chan_irq & ~irq_prev_q;
  assign mask_we  = wr_en && (wr_size == SZ_BYTE) && (off == OFF_MODE);

  always_ff @(posedge clk) begin
    if (rst) irq_prev_q <= '0;
    else     irq_prev_q <= chan_irq;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmr_chan_regs #(.EXT(EXT_REGS), .ST_EN_RST(ST_EN_RST)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en && (sel == 1'(c))),
      .wr_off   (off),
      .wr_size  (wr_size),
      .wr_data  (wr_data),
      .busy     (chan_busy[c]),
      .fault    (chan_fault[c]),
      .irq_rise (irq_rise[c]),
      .cmd_q    (cmd_a[c]),
      .stat_q   (stat_a[c]),
      .time_q   (time_a[c]),
      .ptr_q    (ptr_a[c]),
      .cur_q    (cur_a[c])
    );
    assign cur_addr[PTR_W*c +: PTR_W] = cur_a[c];
  end

  bmr_mode_irq #(.EXT(EXT_REGS)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .chan_irq (chan_irq),
    .mask_we  (mask_we),
    .mask_wd  (wr_data[MASK_LSB +: NUM_CH]),
    .mode_q   (mode_w),
    .irq_out  (irq_out)
  );

  always_comb begin
    if (off[OFF_W-1]) begin
      rd_nx = ptr_a[sel][REG_W*off[1:0] +: REG_W];
    end else begin
      unique case (off[1:0])
        2'd0:    rd_nx = cmd_a[sel];
        2'd1:    rd_nx = EXT_REGS ? mode_w : ABSENT;
        2'd2:    rd_nx = stat_a[sel];
        default: rd_nx = EXT_REGS ? time_a[sel] : ABSENT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_nx;
    end
  end
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker
  import bmr_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [1:0]        wr_size,
  input logic [PTR_W-1:0]  wr_data,
  input logic              rd_en,
  input logic [REG_W-1:0]  rd_data,
  input logic              rd_valid,
  input logic [NUM_CH-1:0] chan_fault,
  input logic [NUM_CH-1:0] chan_irq,
  input logic              irq_out,
  input logic [REG_W-1:0]  mode_q,
  input logic [REG_W-1:0]  stat0
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  p_pend_track_r5: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (mode_q[PEND_LSB +: NUM_CH] == $past(chan_irq)));
  p_irq_mix_r6: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (irq_out ==
      $past(|(mode_q[PEND_LSB +: NUM_CH] & ~mode_q[MASK_LSB +: NUM_CH]))));
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'h2 && wr_size == 2'd0 && wr_data[1] && !chan_fault[0])
      |=> !stat0[1]);
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!irq_out && !rd_valid));

  if (!EXT) begin : g_red
    p_absent_ff_r11: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr[0] && !addr[2]) |=> (rd_data == 8'hFF));
  end
endmodule

bind busmaster_regs bmr_checker #(.EXT(EXT_REGS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_size    (wr_size),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .chan_fault (chan_fault),
  .chan_irq   (chan_irq),
  .irq_out    (irq_out),
  .mode_q     (mode_w),
  .stat0      (stat_a[0])
);

// File: tb/busmaster_regs_tb_top.sv
module busmaster_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  chan_busy = '0, chan_fault = '0, chan_irq = '0;
  logic [7:0]  rd_data, rd_data_r;
  logic        rd_valid, rd_valid_r, irq_out, irq_r;
  logic [63:0] cur_addr, cur_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  byte unsigned exp_q[$];
  byte unsigned exp_rq[$];
  string        tag_q[$];
  string        tag_rq[$];

  always #10 clk = ~clk;

  busmaster_regs #(.EXT_REGS(1'b1)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .chan_busy(chan_busy), .chan_fault(chan_fault), .chan_irq(chan_irq),
    .irq_out(irq_out), .cur_addr(cur_addr));

  busmaster_regs #(.EXT_REGS(1'b0)) dut_red_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data_r), .rd_valid(rd_valid_r),
    .chan_busy(chan_busy), .chan_fault(chan_fault), .chan_irq(chan_irq),
    .irq_out(irq_r), .cur_addr(cur_r));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz);
    addr = a; wr_data = d; wr_size = sz; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes expected bytes for both variants, then issues the read
  task automatic rd(input logic [3:0] a, input byte unsigned exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    exp_rq.push_back((a[2] == 1'b0 && a[0] == 1'b1) ? 8'hFF : exp);
    tag_rq.push_back({tag, " reduced"});
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops and compares as read data appears
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected valid", 1, 0);
        else begin
          byte unsigned e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rd_data == e, t, rd_data, e);
        end
      end
      if (rd_valid_r) begin
        if (exp_rq.size() == 0) check(1'b0, "R10 unexpected valid reduced", 1, 0);
        else begin
          byte unsigned e;
          string t;
          e = exp_rq.pop_front();
          t = tag_rq.pop_front();
          check(rd_data_r == e, t, rd_data_r, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    check(irq_out == 1'b0, "R9 irq low after reset", irq_out, 0);
    rd(4'h2, 8'h20, "R9 status reset");
    rd(4'h0, 8'h00, "R9 command reset");
    rd(4'h1, 8'h00, "R9 mode reset");
    rd(4'hC, 8'h00, "R9 pointer reset");

    // R2 / R1 command per channel
    wr(4'h0, 32'hA5, 2'd0);
    wr(4'h8, 32'h3C, 2'd0);
    rd(4'h0, 8'hA5, "R2 cmd ch0");
    rd(4'h8, 8'h3C, "R1 cmd ch1 window");

    // R7 timing, R11 absent in reduced
    wr(4'h3, 32'h11, 2'd0);
    wr(4'hB, 32'h77, 2'd0);
    rd(4'h3, 8'h11, "R7 timing ch0");
    rd(4'hB, 8'h77, "R7 timing ch1");

    // R8 descriptor pointer lanes
    wr(4'h4, 32'hDEADBEEF, 2'd2);
    check(cur_addr[31:0] == 32'hDEADBEEF, "R8 cur word", cur_addr[31:0], 32'hDEADBEEF);
    rd(4'h4, 8'hEF, "R8 byte4");
    rd(4'h7, 8'hDE, "R8 byte7");
    wr(4'h6, 32'h00001234, 2'd1);
    check(cur_addr[31:0] == 32'h1234BEEF, "R8 cur half", cur_addr[31:0], 32'h1234BEEF);
    rd(4'h7, 8'h12, "R8 half upper lane");
    wr(4'hC, 32'h0000005A, 2'd0);
    check(cur_addr[63:32] == 32'h5A, "R8 cur ch1 byte", cur_addr[63:32], 32'h5A);
    check(cur_addr[31:0] == 32'h1234BEEF, "R8 ch0 untouched", cur_addr[31:0], 32'h1234BEEF);

    // R3 status write rule
    wr(4'h2, 32'hFF, 2'd0);
    rd(4'h2, 8'h60, "R3 status write");
    chan_busy[0] = 1'b1;
    tick(1);
    rd(4'h2, 8'h61, "R3 busy mirror");
    chan_busy[0] = 1'b0;
    wr(4'h2, 32'h00, 2'd0);
    rd(4'h2, 8'h01, "R3 bit0 held on write");
    rd(4'h2, 8'h00, "R3 bit0 follows busy");

    // R4 fault set, R10 reads have no side effect
    chan_fault[0] = 1'b1;
    tick(1);
    chan_fault[0] = 1'b0;
    rd(4'h2, 8'h02, "R4 fault sets bit1");
    rd(4'h2, 8'h02, "R10 reread unchanged");
    wr(4'h2, 32'h02, 2'd0);
    rd(4'h2, 8'h00, "R3 w1c bit1");

    // R5 / R6 interrupts
    chan_irq[1] = 1'b1;
    tick(1);
    check(irq_out == 1'b0, "R6 registered latency", irq_out, 0);
    tick(1);
    check(irq_out == 1'b1, "R6 ch1 irq", irq_out, 1);
    check(irq_r == 1'b1, "R11 reduced irq", irq_r, 1);
    rd(4'h1, 8'h08, "R5 pending ch1");
    rd(4'hA, 8'h24, "R4 irq sets status bit2");
    wr(4'h9, 32'hFF, 2'd0);
    tick(1);
    check(irq_out == 1'b0, "R6 masked", irq_out, 0);
    check(irq_r == 1'b1, "R11 mask write ignored", irq_r, 1);
    rd(4'h1, 8'h38, "R5 mask bits only");
    wr(4'hA, 32'h04, 2'd0);
    rd(4'hA, 8'h00, "R3 w1c bit2");
    chan_irq[1] = 1'b0;
    tick(2);
    rd(4'h9, 8'h30, "R5 pending cleared");
    wr(4'h1, 32'h00, 2'd0);
    chan_irq[0] = 1'b1;
    tick(2);
    check(irq_out == 1'b1, "R6 ch0 irq", irq_out, 1);
    rd(4'h1, 8'h04, "R5 pending ch0");
    chan_irq[0] = 1'b0;
    tick(2);
    check(irq_out == 1'b0, "R6 ch0 falls", irq_out, 0);

    tick(2);
    check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    check(exp_rq.size() == 0, "R10 all reduced reads returned", exp_rq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule